// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block walks the column addresses of one memory burst. A column command strobe loads a start column together with a length code, an ordering choice (linear or interleaved) and the direction of the access. From the next cycle on, the block presents one column per clock with a valid flag, and it raises a final-beat flag on the closing beat of a finite burst. A full-row burst steps through all 256 columns and wraps. It keeps running until a stop strobe or a new command ends it.

A new command may arrive on any cycle, including every cycle in a row. It replaces the running burst at once, and the new start column appears in the following cycle. A stop strobe ends the burst, so the cycle after it shows no valid column. A single-write option forces every write burst down to one beat, while read bursts keep the programmed length.

The control is a three-state machine. ST_IDLE is the rest state and holds no burst. ST_BURST runs a finite burst. ST_PAGE runs a full-row burst. The transitions are:

- LOAD_FINITE: a command with a finite effective length, taken from any state into ST_BURST.
- LOAD_PAGE: a command with full-row length, taken from any state into ST_PAGE.
- FINISH: ST_BURST back to ST_IDLE on its final beat.
- HALT: ST_BURST or ST_PAGE back to ST_IDLE on a stop strobe.

When a command and a stop strobe come in the same cycle, the command wins.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o and last_o are both 0 until the first command.
- R2: The cycle after cmd_i is sampled high, valid_o is 1 and col_o equals the start_col_i value sampled with it.
- R3: In linear order (ilv_i=0) with length L of 2, 4 or 8, beat n shows the start column with its low log2(L) bits replaced by (start + n) mod L. Upper bits are unchanged.
- R4: In interleaved order (ilv_i=1) with length L, beat n shows start XOR n, for n from 0 to L-1.
- R5: Length code 7 with linear order is a full-row burst. Beat n shows (start + n) mod 256, last_o stays 0, and the burst never ends by itself.
- R6: len_code_i values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. last_o is 1 only on the final beat of a finite burst, and valid_o is 0 in the cycle after that beat unless a new command was sampled.
- R7: A stop_i sampled high without cmd_i makes valid_o 0 in the next cycle. If stop_i and cmd_i are high together, the command is taken and the stop is ignored.
- R8: A command sampled during a running burst discards the remaining beats. The next cycle starts the new burst from its own start column, order and length.
- R9: With single_wr_i=1, a write command (wr_i=1) gives a one-beat burst with last_o=1 on that beat. A read command keeps its programmed length.
- R10: Length code 7 with interleaved order, and the unused codes 4, 5 and 6, each give a one-beat burst.
- R11: Commands on consecutive cycles are each honoured. Every one shows its own start column in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 1 | Column command strobe (start or restart) |
| stop_i | input | 1 | Burst stop strobe |
| wr_i | input | 1 | 1 for a write command, 0 for a read |
| single_wr_i | input | 1 | Single-write option: writes become one beat |
| ilv_i | input | 1 | 1 selects interleaved order, 0 linear |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 7 gives full row |
| start_col_i | input | COL_W | Start column of the burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Current beat is the final one of a finite burst |

## Verification
The bench goes after start columns that sit mid-block, so that linear wrapping is visible. A design that carried into the upper bits instead of wrapping would leave the aligned block. The same start column is run in interleaved order, where a design that added instead of XORing the beat index shows the wrong sequence from the second beat on.

A full-row burst is run past 256 beats. This exposes a counter that ends the burst, raises last_o, or fails to wrap. Restarts, back-to-back commands, and a stop paired with a command check that the newer command always wins and that no stale beat leaks out. The single-write and illegal-length cases check that only writes are shortened and that illegal codes collapse to one beat rather than running on.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_t;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             wr_i,
    input  logic             single_wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    logic force_one;

    always_comb begin
        force_one = wr_i && single_wr_i;
        mask_o    = '0;
        page_o    = 1'b0;
        unique case (len_code_i)
            LEN_1:    mask_o = COL_W'(0);
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                if (!ilv_i) begin
                    mask_o = '1;
                    page_o = 1'b1;
                end
            end
            default:  mask_o = '0;
        endcase
        if (force_one) begin
            mask_o = '0;
            page_o = 1'b0;
        end
    end
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] beat_o,
    output logic             ilv_o,
    output logic             valid_o,
    output logic             last_o
);
    burst_state_t state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q, beat_q;
    logic             ilv_q;
    logic             at_end;

    assign at_end = (state_q == ST_BURST) && (beat_q == mask_q);

    always_comb begin
        state_d = state_q;
        if (cmd_i) begin
            state_d = page_i ? ST_PAGE : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: if (stop_i || at_end) state_d = ST_IDLE;
                ST_PAGE:  if (stop_i) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            beat_q <= '0;
            ilv_q  <= 1'b0;
        end else if (cmd_i) begin
            base_q <= start_col_i;
            mask_q <= mask_i;
            beat_q <= '0;
            ilv_q  <= ilv_i;
        end else if (state_q != ST_IDLE) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        valid_o = (state_q != ST_IDLE);
        last_o  = at_end;
        base_o  = base_q;
        mask_o  = mask_q;
        beat_o  = beat_q;
        ilv_o   = ilv_q;
    end
endmodule

// File: rtl/col_order.sv
module col_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] lin_col, ilv_col, sum;

    always_comb begin
        sum     = base_i + beat_i;
        lin_col = (base_i & ~mask_i) | (sum & mask_i);
        ilv_col = base_i ^ (beat_i & mask_i);
        col_o   = ilv_i ? ilv_col : lin_col;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             stop_i,
    input  logic             wr_i,
    input  logic             single_wr_i,
    input  logic             ilv_i,
    input  logic [2:0]       len_code_i,
    input  logic [COL_W-1:0] start_col_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] dec_mask, base, mask, beat;
    logic             dec_page, ilv_run;

    burst_len_dec #(.COL_W(COL_W)) u_dec (
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .wr_i       (wr_i),
        .single_wr_i(single_wr_i),
        .mask_o     (dec_mask),
        .page_o     (dec_page)
    );

    burst_fsm #(.COL_W(COL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .stop_i     (stop_i),
        .start_col_i(start_col_i),
        .mask_i     (dec_mask),
        .page_i     (dec_page),
        .ilv_i      (ilv_i),
        .base_o     (base),
        .mask_o     (mask),
        .beat_o     (beat),
        .ilv_o      (ilv_run),
        .valid_o    (valid_o),
        .last_o     (last_o)
    );

    col_order #(.COL_W(COL_W)) u_ord (
        .base_i(base),
        .mask_i(mask),
        .beat_i(beat),
        .ilv_i (ilv_run),
        .col_o (col_o)
    );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_i,
    input logic             stop_i,
    input logic             wr_i,
    input logic             single_wr_i,
    input logic             ilv_i,
    input logic [2:0]       len_code_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);
    // R6: a final-beat flag only accompanies a valid beat
    a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R2: a command shows its start column next cycle
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> (valid_o && col_o == $past(start_col_i)));

    // R6: nothing follows the final beat without a new command
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !cmd_i) |=> !valid_o);

    // R7: stop without command ends the burst
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !cmd_i) |=> !valid_o);

    // R9: single-write shortens writes to one beat
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && wr_i && single_wr_i) |=> last_o);

    // R10: full-row code with interleaved order is one beat
    a_r10_ilv_page_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && ilv_i && len_code_i == 3'd7) |=> last_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .stop_i(stop_i), .wr_i(wr_i),
    .single_wr_i(single_wr_i), .ilv_i(ilv_i), .len_code_i(len_code_i),
    .start_col_i(start_col_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    typedef struct {
        logic [7:0] col;
        logic       last;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_i = 1'b0, stop_i = 1'b0, wr_i = 1'b0, single_wr_i = 1'b0, ilv_i = 1'b0;
    logic [2:0] len_code_i = 3'd0;
    logic [7:0] start_col_i = 8'd0;
    logic [7:0] col_o;
    logic       valid_o, last_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .stop_i(stop_i), .wr_i(wr_i),
        .single_wr_i(single_wr_i), .ilv_i(ilv_i), .len_code_i(len_code_i),
        .start_col_i(start_col_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard at every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6 extra beat", int'(col_o), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(col_o == e.col, {e.tag, " col"}, int'(col_o), int'(e.col));
                    check(last_o == e.last, {e.tag, " last"}, int'(last_o), int'(e.last));
                end
            end else begin
                if (last_o) check(1'b0, "R6 last without valid", 1, 0);
                if (sb.size() != 0) begin
                    check(1'b0, {sb[0].tag, " missing beat"}, 0, int'(sb[0].col));
                    sb.delete();
                end
            end
        end
    end

    // Driver: computes the expected beats from the requirements
    task automatic issue(input logic [7:0] st, input logic [2:0] code, input bit ilv,
                         input bit wr, input bit sw, input bit with_stop,
                         input int n_wait, input int page_beats, input string tag);
        int  len;
        bit  page;
        sb.delete();
        page = (code == 3'd7) && !ilv && !(wr && sw);
        if (wr && sw)        len = 1;
        else if (code <= 3)  len = 1 << code;
        else                 len = 1;
        if (page) len = page_beats;
        for (int i = 0; i < len; i++) begin
            exp_t e;
            if (page)     e.col = 8'((int'(st) + i) % 256);
            else if (ilv) e.col = st ^ 8'(i);
            else          e.col = 8'((int'(st) - (int'(st) % len)) + ((int'(st) + i) % len));
            e.last = !page && (i == len - 1);
            e.tag  = tag;
            sb.push_back(e);
        end
        start_col_i = st; len_code_i = code; ilv_i = ilv; wr_i = wr; single_wr_i = sw;
        cmd_i = 1'b1; stop_i = with_stop;
        @(negedge clk); #1;
        cmd_i = 1'b0; stop_i = 1'b0;
        repeat (n_wait - 1) begin @(negedge clk); #1; end
    endtask

    task automatic do_stop();
        sb.delete();
        stop_i = 1'b1;
        @(negedge clk); #1;
        stop_i = 1'b0;
        check(valid_o == 1'b0, "R7 stop ends burst", int'(valid_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
        check(last_o == 1'b0, "R1 reset last", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(valid_o == 1'b0, "R1 idle valid", int'(valid_o), 0);

        issue(8'h0E, 3'd2, 0, 0, 0, 0, 6, 0, "R3 lin len4");
        issue(8'h35, 3'd3, 0, 0, 0, 0, 10, 0, "R3 lin len8");
        issue(8'h35, 3'd3, 1, 0, 0, 0, 10, 0, "R4 ilv len8");
        issue(8'h81, 3'd1, 1, 0, 0, 0, 4, 0, "R4 ilv len2");
        issue(8'h7F, 3'd0, 0, 0, 0, 0, 3, 0, "R6 len1");
        issue(8'hF0, 3'd7, 0, 0, 0, 0, 300, 300, "R5 full row");
        do_stop();
        issue(8'h10, 3'd3, 0, 0, 0, 0, 3, 0, "R8 first");
        issue(8'h42, 3'd2, 1, 0, 0, 0, 6, 0, "R8 restart");
        issue(8'h20, 3'd3, 0, 1, 0, 0, 2, 0, "R7 stopped");
        do_stop();
        issue(8'h55, 3'd2, 0, 0, 0, 1, 6, 0, "R7 cmd beats stop");
        issue(8'h60, 3'd3, 0, 1, 1, 0, 3, 0, "R9 write single");
        issue(8'h61, 3'd3, 0, 0, 1, 0, 10, 0, "R9 read keeps len");
        issue(8'h62, 3'd3, 0, 1, 0, 0, 10, 0, "R9 write no option");
        issue(8'h93, 3'd7, 1, 0, 0, 0, 3, 0, "R10 ilv full code");
        issue(8'h94, 3'd5, 0, 0, 0, 0, 3, 0, "R10 unused code");
        issue(8'hA0, 3'd3, 0, 0, 0, 0, 1, 0, "R11 b2b one");
        issue(8'hB3, 3'd2, 1, 0, 0, 0, 1, 0, "R11 b2b two");
        issue(8'hC6, 3'd2, 0, 0, 0, 0, 6, 0, "R11 b2b three");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule